// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This unit carries out a family of signed multiplies whose second factor is always a 16-bit half of a source word. Five operations share one datapath. The first is a 16x16 product. The second adds that product to a 32-bit accumulator. The third adds it to a 64-bit accumulator split across two words. The fourth is a 32x16 product that keeps its upper 32 of 48 bits, and the fifth adds a 32-bit accumulator to that slice. An outside decoder supplies the operand values and a 3-bit operation code. It also supplies two half-select bits, one per multiplicand.

Each request produces a registered result one cycle later. The result comes with per-word write enables and a strobe that asks the owner of the sticky overflow flag to set it. Results wrap and are never saturated. Only the two 32-bit accumulate forms raise the strobe. A build parameter selects the older architecture variant, in which the 16x16 form with 32-bit accumulate does nothing.

Top module: `hmac_unit`

## Requirements
- R1: After reset `valid_o`, `wr_lo_o`, `wr_hi_o` and `q_set_o` are 0. A request sampled with `req_i` high gives `valid_o` high on the following clock edge. With no request, all four outputs are 0.
- R2: For the 16-bit forms (codes 0, 1, 2), `x_sel_i` set selects `opa_i[31:16]` and clear selects `opa_i[15:0]`. For every form, `y_sel_i` picks the half of `opb_i` in the same way. Each selected half is read as a signed 16-bit value.
- R3: Code 0 (16x16 multiply) writes the low 32 bits of the signed product to `res_lo_o` with `wr_lo_o` high, and never raises `q_set_o`.
- R4: Code 1 (16x16 plus 32-bit accumulate) writes the wrapped 32-bit sum of the product and `acc_lo_i`. It raises `q_set_o` exactly when that sum leaves the signed 32-bit range.
- R5: Code 2 (16x16 plus 64-bit accumulate) adds the sign-extended product to `{acc_hi_i, acc_lo_i}` modulo 2^64. It writes the two halves to `res_hi_o`/`res_lo_o` with both enables high, and never raises `q_set_o`.
- R6: Code 3 (32x16 multiply) multiplies all of `opa_i`, signed, by the selected signed half of `opb_i`. It writes bits 47:16 of the 48-bit product and never raises `q_set_o`.
- R7: Code 4 (32x16 plus accumulate) writes the wrapped sum of that 32-bit slice and `acc_lo_i`. It raises `q_set_o` exactly on signed 32-bit overflow of the sum.
- R8: With `LEGACY_ARCH` = 1, code 1 still returns `valid_o` but leaves `wr_lo_o`, `wr_hi_o` and `q_set_o` at 0. All other codes behave as without the parameter.
- R9: Codes 5 to 7 return `valid_o` with no write enable and no `q_set_o`.
- R10: `wr_hi_o` is high only for code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| op_i | input | 3 | Operation code (0..4 defined) |
| x_sel_i | input | 1 | Upper-half select for the first multiplicand |
| y_sel_i | input | 1 | Upper-half select for the second multiplicand |
| opa_i | input | 32 | First multiplicand word |
| opb_i | input | 32 | Second multiplicand word |
| acc_lo_i | input | 32 | 32-bit accumulator, or low word of the 64-bit one |
| acc_hi_i | input | 32 | High word of the 64-bit accumulator |
| valid_o | output | 1 | Result valid, one cycle after the request |
| wr_lo_o | output | 1 | Write enable for the low result word |
| wr_hi_o | output | 1 | Write enable for the high result word |
| q_set_o | output | 1 | Request to set the sticky overflow flag |
| res_lo_o | output | 32 | Result word, or low word of the 64-bit sum |
| res_hi_o | output | 32 | High word of the 64-bit sum |

## Verification
The in-line assertions check the control behaviour on every cycle. They cover the one-cycle request-to-valid timing, and that the overflow strobe and the enables never appear without `valid_o`. They also check that the strobe comes only from the two 32-bit accumulate forms, that the high-word enable belongs only to the 64-bit form, and that the legacy variant and the undefined codes write nothing. Inside the adder, an assertion compares the overflow flag against a widened sum on every evaluation. The numeric results can only be shown by the bench's scenarios. These cover the four half-select combinations, and overflow in both directions at the range edges. They also cover a carry and borrow across the two accumulator words, the 47:16 slice at the most negative operands, and a random mix run against an independent model.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  typedef enum logic [2:0] {
    OP_MUL16  = 3'd0,
    OP_MLA16  = 3'd1,
    OP_MLAL16 = 3'd2,
    OP_MULW   = 3'd3,
    OP_MLAW   = 3'd4
  } hmac_op_e;
endpackage

// File: rtl/hmac_operand.sv
// Picks the multiplicands: signed half or full word for A, signed half for B.
module hmac_operand #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              x_sel_i,
  input  logic              y_sel_i,
  input  logic              wide_a_i,
  output logic [DATA_W-1:0] a_ext_o,
  output logic [HALF_W-1:0] b_half_o
);
  logic [HALF_W-1:0] a_half;

  assign a_half   = x_sel_i ? opa_i[DATA_W-1:HALF_W] : opa_i[HALF_W-1:0];
  assign b_half_o = y_sel_i ? opb_i[DATA_W-1:HALF_W] : opb_i[HALF_W-1:0];
  // R2: half operands are sign extended
  assign a_ext_o  = wide_a_i ? opa_i : {{HALF_W{a_half[HALF_W-1]}}, a_half};
endmodule

// File: rtl/hmac_mult.sv
module hmac_mult #(
  parameter int A_W = 32,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] prod_o
);
  logic signed [P_W-1:0] a_x;
  logic signed [P_W-1:0] b_x;

  assign a_x    = {{B_W{a_i[A_W-1]}}, a_i};
  assign b_x    = {{A_W{b_i[B_W-1]}}, b_i};
  assign prod_o = a_x * b_x;
endmodule

// File: rtl/hmac_add.sv
// Wrapping signed adder with overflow detect.
module hmac_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  assign sum_o = a_i + b_i;
  assign ovf_o = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);

  logic [W:0] wide_sum;
  assign wide_sum = {a_i[W-1], a_i} + {b_i[W-1], b_i};

  // R4 R7
  always_comb begin
    ovf_match_chk: assert (ovf_o == (wide_sum[W] != wide_sum[W-1]))
      else $error("adder overflow flag disagrees with widened sum");
  end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter bit LEGACY_ARCH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic              x_sel_i,
  input  logic              y_sel_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] acc_lo_i,
  input  logic [DATA_W-1:0] acc_hi_i,
  output logic              valid_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              q_set_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic [DATA_W-1:0] res_hi_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PROD_W = DATA_W + HALF_W;
  localparam int LONG_W = 2 * DATA_W;

  hmac_op_e op;
  assign op = hmac_op_e'(op_i);

  logic              wide_a;
  logic [DATA_W-1:0] a_ext;
  logic [HALF_W-1:0] b_half;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] mul_word;
  logic [DATA_W-1:0] acc_sum;
  logic              acc_ovf;
  logic [LONG_W-1:0] long_sum;

  assign wide_a = (op == OP_MULW) || (op == OP_MLAW);

  hmac_operand #(.DATA_W(DATA_W)) u_operand (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .x_sel_i (x_sel_i),
    .y_sel_i (y_sel_i),
    .wide_a_i(wide_a),
    .a_ext_o (a_ext),
    .b_half_o(b_half)
  );

  hmac_mult #(.A_W(DATA_W), .B_W(HALF_W)) u_mult (
    .a_i   (a_ext),
    .b_i   (b_half),
    .prod_o(prod)
  );

  // R6: wide forms keep the upper slice, half forms the low word
  assign mul_word = wide_a ? prod[PROD_W-1:HALF_W] : prod[DATA_W-1:0];

  hmac_add #(.W(DATA_W)) u_add (
    .a_i  (mul_word),
    .b_i  (acc_lo_i),
    .sum_o(acc_sum),
    .ovf_o(acc_ovf)
  );

  // R5: 64-bit accumulate, wraps
  assign long_sum = {acc_hi_i, acc_lo_i}
                  + {{(LONG_W-PROD_W){prod[PROD_W-1]}}, prod};

  logic              wlo_d, whi_d, q_d;
  logic [DATA_W-1:0] lo_d, hi_d;

  always_comb begin
    wlo_d = 1'b0;
    whi_d = 1'b0;
    q_d   = 1'b0;
    lo_d  = mul_word;
    hi_d  = '0;
    unique case (op)
      OP_MUL16: wlo_d = 1'b1;
      OP_MLA16: begin
        if (!LEGACY_ARCH) begin
          wlo_d = 1'b1;
          lo_d  = acc_sum;
          q_d   = acc_ovf;
        end
      end
      OP_MLAL16: begin
        wlo_d = 1'b1;
        whi_d = 1'b1;
        lo_d  = long_sum[DATA_W-1:0];
        hi_d  = long_sum[LONG_W-1:DATA_W];
      end
      OP_MULW: wlo_d = 1'b1;
      OP_MLAW: begin
        wlo_d = 1'b1;
        lo_d  = acc_sum;
        q_d   = acc_ovf;
      end
      default: ;
    endcase
  end

  logic [2:0] op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_lo_o  <= 1'b0;
      wr_hi_o  <= 1'b0;
      q_set_o  <= 1'b0;
      res_lo_o <= '0;
      res_hi_o <= '0;
      op_q     <= '0;
    end else begin
      valid_o  <= req_i;
      wr_lo_o  <= req_i & wlo_d;
      wr_hi_o  <= req_i & whi_d;
      q_set_o  <= req_i & q_d;
      op_q     <= op_i;
      if (req_i) begin
        res_lo_o <= lo_d;
        res_hi_o <= hi_d;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  // R1
  strobe_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_o || wr_hi_o || q_set_o) |-> valid_o);

  // R3 R5 R6
  q_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_set_o |-> (op_q == OP_MLA16 || op_q == OP_MLAW));

  // R10
  hi_only_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_o |-> (wr_lo_o && op_q == OP_MLAL16));

  // R9
  undef_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_q > OP_MLAW) |-> !(wr_lo_o || q_set_o));

  generate
    if (LEGACY_ARCH) begin : g_legacy
      // R8
      legacy_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && op_q == OP_MLA16) |-> !(wr_lo_o || wr_hi_o || q_set_o));
    end
  endgenerate
endmodule

// File: tb/hmac_unit_bench.sv
module hmac_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, req, x_sel, y_sel;
  logic [2:0]  op;
  logic [31:0] opa, opb, acc_lo, acc_hi;
  logic        m_valid, m_wlo, m_whi, m_q;
  logic [31:0] m_lo, m_hi;
  logic        l_valid, l_wlo, l_whi, l_q;
  logic [31:0] l_lo, l_hi;

  hmac_unit #(.DATA_W(32), .LEGACY_ARCH(1'b0)) u_hmac_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op),
    .x_sel_i(x_sel), .y_sel_i(y_sel), .opa_i(opa), .opb_i(opb),
    .acc_lo_i(acc_lo), .acc_hi_i(acc_hi),
    .valid_o(m_valid), .wr_lo_o(m_wlo), .wr_hi_o(m_whi), .q_set_o(m_q),
    .res_lo_o(m_lo), .res_hi_o(m_hi)
  );

  hmac_unit #(.DATA_W(32), .LEGACY_ARCH(1'b1)) u_hmac_unit_legacy (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op),
    .x_sel_i(x_sel), .y_sel_i(y_sel), .opa_i(opa), .opb_i(opb),
    .acc_lo_i(acc_lo), .acc_hi_i(acc_hi),
    .valid_o(l_valid), .wr_lo_o(l_wlo), .wr_hi_o(l_whi), .q_set_o(l_q),
    .res_lo_o(l_lo), .res_hi_o(l_hi)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] f_op, input logic fx, fy,
      input logic [31:0] a, b, lo, hi, input logic legacy,
      output logic e_wlo, e_whi, e_q, output logic [31:0] e_lo, e_hi);
    logic signed [15:0] ha, hb;
    longint pa, pb, p, s32;
    logic [31:0] w;
    logic [63:0] s64;
    ha = fx ? a[31:16] : a[15:0];
    hb = fy ? b[31:16] : b[15:0];
    pb = longint'(hb);
    pa = (f_op == 3'd3 || f_op == 3'd4) ? longint'($signed(a)) : longint'(ha);
    p  = pa * pb;
    w  = (f_op == 3'd3 || f_op == 3'd4) ? p[47:16] : p[31:0];
    s32 = longint'($signed(w)) + longint'($signed(lo));
    s64 = {hi, lo} + p;
    e_wlo = 1'b0; e_whi = 1'b0; e_q = 1'b0; e_lo = 32'h0; e_hi = 32'h0;
    case (f_op)
      3'd0, 3'd3: begin e_wlo = 1'b1; e_lo = w; end
      3'd1, 3'd4: begin
        if (!(legacy && f_op == 3'd1)) begin
          e_wlo = 1'b1;
          e_lo  = s32[31:0];
          e_q   = (s32 > 64'sd2147483647) || (s32 < -64'sd2147483648);
        end
      end
      3'd2: begin e_wlo = 1'b1; e_whi = 1'b1; e_lo = s64[31:0]; e_hi = s64[63:32]; end
      default: ;
    endcase
  endfunction

  // One request, checked on both instances one cycle later.
  task automatic do_op(input string rq, input logic [2:0] o, input logic fx, fy,
                       input logic [31:0] a, b, lo, hi);
    logic wlo, whi, q;
    logic [31:0] elo, ehi;
    string lrq;
    @(negedge clk);
    req = 1'b1; op = o; x_sel = fx; y_sel = fy;
    opa = a; opb = b; acc_lo = lo; acc_hi = hi;
    @(negedge clk);
    req = 1'b0;
    model(o, fx, fy, a, b, lo, hi, 1'b0, wlo, whi, q, elo, ehi);
    chk(rq, "valid", {63'h0, m_valid}, 64'h1);
    chk(rq, "wr_lo", {63'h0, m_wlo}, {63'h0, wlo});
    chk(rq, "wr_hi", {63'h0, m_whi}, {63'h0, whi});
    chk(rq, "q_set", {63'h0, m_q}, {63'h0, q});
    if (wlo) chk(rq, "res_lo", {32'h0, m_lo}, {32'h0, elo});
    if (whi) chk(rq, "res_hi", {32'h0, m_hi}, {32'h0, ehi});
    lrq = (o == 3'd1) ? "R8" : rq;
    model(o, fx, fy, a, b, lo, hi, 1'b1, wlo, whi, q, elo, ehi);
    chk(lrq, "legacy valid", {63'h0, l_valid}, 64'h1);
    chk(lrq, "legacy wr_lo", {63'h0, l_wlo}, {63'h0, wlo});
    chk(lrq, "legacy wr_hi", {63'h0, l_whi}, {63'h0, whi});
    chk(lrq, "legacy q_set", {63'h0, l_q}, {63'h0, q});
    if (wlo) chk(lrq, "legacy res_lo", {32'h0, l_lo}, {32'h0, elo});
    if (whi) chk(lrq, "legacy res_hi", {32'h0, l_hi}, {32'h0, ehi});
  endtask

  task automatic t_reset();
    // R1
    chk("R1", "reset valid", {63'h0, m_valid}, 64'h0);
    chk("R1", "reset strobes", {60'h0, m_wlo, m_whi, m_q, l_valid}, 64'h0);
  endtask

  task automatic t_idle();
    // R1: no request, nothing raised
    @(negedge clk);
    chk("R1", "idle valid", {63'h0, m_valid}, 64'h0);
    chk("R1", "idle strobes", {61'h0, m_wlo, m_whi, m_q}, 64'h0);
  endtask

  task automatic t_halves();
    // R2 R3: all four half combinations
    for (int i = 0; i < 4; i++)
      do_op("R2", 3'd0, i[1], i[0], 32'h8001_7FFF, 32'hFFFE_0003, 32'h0, 32'h0);
    do_op("R3", 3'd0, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h0, 32'h0);
  endtask

  task automatic t_mla16();
    // R4
    do_op("R4", 3'd1, 1'b0, 1'b1, 32'h0000_0010, 32'h0020_0000, 32'h0000_0100, 32'h0);
    do_op("R4", 3'd1, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 32'h0);
    do_op("R4", 3'd1, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 32'h0);
    do_op("R4", 3'd1, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFE, 32'h0);
  endtask

  task automatic t_mlal();
    // R5 R10: carry and borrow across words
    do_op("R5", 3'd2, 1'b0, 1'b0, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'h0);
    do_op("R5", 3'd2, 1'b0, 1'b0, 32'hFFFF, 32'h1, 32'h0, 32'h0);
    do_op("R5", 3'd2, 1'b1, 1'b1, 32'h7FFF_0000, 32'h7FFF_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
  endtask

  task automatic t_mulw();
    // R6
    do_op("R6", 3'd3, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h0, 32'h0);
    do_op("R6", 3'd3, 1'b0, 1'b1, 32'h1234_5678, 32'hFFFF_0000, 32'h7FFF_FFFF, 32'h0);
  endtask

  task automatic t_mlaw();
    // R7
    do_op("R7", 3'd4, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 32'h0);
    do_op("R7", 3'd4, 1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_0000, 32'hC000_0000, 32'h0);
    do_op("R7", 3'd4, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0002, 32'h0000_0005, 32'h0);
  endtask

  task automatic t_undef();
    // R9
    for (int c = 5; c < 8; c++)
      do_op("R9", c[2:0], 1'b1, 1'b0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 32'h1);
  endtask

  task automatic t_random();
    for (int k = 0; k < 60; k++)
      do_op("R2", 3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
            $urandom, $urandom, $urandom, $urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; op = 3'd0; x_sel = 1'b0; y_sel = 1'b0;
    opa = '0; opb = '0; acc_lo = '0; acc_hi = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_halves();
    t_mla16();
    t_mlal();
    t_mulw();
    t_mlaw();
    t_undef();
    t_idle();
    t_random();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule